// File: doc/BRIEF.md
# Instrument Status Register Set

This block keeps the status registers that a programmable load reports to its host. One register follows a set of hardware condition lines cycle by cycle. A second register latches trip conditions until the host reads them. A third register records protocol events such as completed operations and command, query and execution errors. Each of these three registers has an 8-bit enable mask that the host writes. When any bit is set both in a register and in its mask, the matching summary bit of the status byte goes high.

The host reaches the block through a small register bus. It has an address, a write strobe with 8-bit write data, a read strobe, and combinational read data. A read of the trip register or the event register returns the value held before the read. The same read then clears that register, except for trip bits whose condition is still true and event bits that are set again in that same cycle. One extra control register holds the input-disabled setting. Its power-up value is 1, or a saved value when the retain option input is high during reset.

Top module: `instr_status_regs`

## Requirements
- R1: Address 0 returns the live input state: bit 7 fault, bit 4 duty-cycle protect, bit 3 below dropout, bit 2 power limiting, bit 1 low source voltage, bit 0 input disabled. Bits 6 and 5 read 0. Reading address 0 changes nothing.
- R2: The input-disabled bit resets to 1 when `retain_i` is low and to `saved_dis_i` when `retain_i` is high. A write to address 6 loads it from write-data bit 0.
- R3: The enable masks sit at address 1 (input state), address 3 (trip) and address 5 (event). Each stores any value from 0 to 255, reads back the last value written, and resets to 0.
- R4: Status byte bit 0 is 1 exactly when the input state and its mask share a set bit.
- R5: A trip register bit is set after any cycle in which its `trip_cond_i` bit is 1. It stays set until a read, and the register is 0 after reset.
- R6: A read of address 2 returns the trip value from before the read. After the read, the register holds exactly the trip conditions present in the read cycle.
- R7: Status byte bit 1 is 1 exactly when the trip register and its mask share a set bit.
- R8: The event register at address 4 uses bit 7 for power-on, bit 5 for command error, bit 4 for execution error, bit 2 for query error and bit 0 for operation complete. It resets to 8'h80, and bits 6, 3 and 1 read 0.
- R9: A read of address 4 returns the event value and then clears it. An event pulse in the read cycle is kept.
- R10: Status byte bit 5 is 1 exactly when the event register and its mask share a set bit. All other status byte bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| retain_i | input | 1 | Keep the saved input-disabled state through reset |
| saved_dis_i | input | 1 | Saved input-disabled state |
| fault_i | input | 1 | Hardware fault condition |
| duty_i | input | 1 | Duty-cycle protect condition |
| dropout_i | input | 1 | Source below dropout condition |
| plimit_i | input | 1 | Power limiting condition |
| lowv_i | input | 1 | Low source voltage condition |
| trip_cond_i | input | 8 | Trip condition lines |
| opc_i | input | 1 | Operation complete pulse |
| qry_err_i | input | 1 | Query error pulse |
| exe_err_i | input | 1 | Execution error pulse |
| cmd_err_i | input | 1 | Command error pulse |
| bus_addr_i | input | 3 | Register address |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rd_i | input | 1 | Read strobe |
| bus_rdata_o | output | 8 | Read data |
| stb_sum_o | output | 8 | Status byte summary bits |

## Verification
The hardest case to reach is a read-clear of the trip or event register that lands in the same cycle as a new set. The bench reaches it by raising an event pulse, or by holding a trip condition, on the same falling edge on which it raises the read strobe. It then checks two things: the read data shows the value from before the read, and a second read shows the bit that survived. The retain option only acts during reset, so the bench runs extra reset sequences with different values of `retain_i` and `saved_dis_i`.

// File: rtl/isr_pkg.sv
package isr_pkg;
    localparam int DW = 8;
    localparam int AW = 3;
    localparam int NMASK = 3;

    typedef enum logic [AW-1:0] {
        A_ISTATE    = 3'd0,
        A_ISTATE_EN = 3'd1,
        A_TRIP      = 3'd2,
        A_TRIP_EN   = 3'd3,
        A_EVENT     = 3'd4,
        A_EVENT_EN  = 3'd5,
        A_CTRL      = 3'd6
    } reg_addr_e;

    // input state bit positions
    localparam int IS_DIS   = 0;
    localparam int IS_LOWV  = 1;
    localparam int IS_PLIM  = 2;
    localparam int IS_DROP  = 3;
    localparam int IS_DUTY  = 4;
    localparam int IS_FAULT = 7;

    // event bit positions
    localparam int EV_OPC = 0;
    localparam int EV_QRY = 2;
    localparam int EV_EXE = 4;
    localparam int EV_CMD = 5;
    localparam int EV_PON = 7;
    localparam logic [DW-1:0] EV_LIVE  = 8'hB5;
    localparam logic [DW-1:0] EV_RESET = 8'h80;

    // status byte positions of the three summaries (state, trip, event)
    localparam int SB_POS [NMASK] = '{0, 1, 5};
endpackage

// File: rtl/isr_enable_mask.sv
module isr_enable_mask #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [DW-1:0] flags_i,
    output logic [DW-1:0] mask_o,
    output logic          hit_o
);
    typedef struct packed {
        logic [DW-1:0] mask;
    } mask_s;

    mask_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) st_d.mask = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mask_o = st_q.mask;
    assign hit_o  = |(st_q.mask & flags_i);
endmodule

// File: rtl/isr_trip_latch.sv
module isr_trip_latch #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] cond_i,
    input  logic          clr_i,
    output logic [DW-1:0] val_o
);
    typedef struct packed {
        logic [DW-1:0] trip;
    } trip_s;

    trip_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) st_d.trip = '0;
        st_d.trip = st_d.trip | cond_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign val_o = st_q.trip;
endmodule

// File: rtl/isr_event_latch.sv
module isr_event_latch #(
    parameter int            DW        = 8,
    parameter logic [DW-1:0] LIVE_MASK = '1,
    parameter logic [DW-1:0] RST_VAL   = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] set_i,
    input  logic          clr_i,
    output logic [DW-1:0] val_o
);
    typedef struct packed {
        logic [DW-1:0] ev;
    } ev_s;

    ev_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) st_d.ev = '0;
        st_d.ev = (st_d.ev | set_i) & LIVE_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.ev <= RST_VAL & LIVE_MASK;
        else        st_q    <= st_d;
    end

    assign val_o = st_q.ev;
endmodule

// File: rtl/instr_status_regs.sv
module instr_status_regs
    import isr_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          retain_i,
    input  logic          saved_dis_i,
    input  logic          fault_i,
    input  logic          duty_i,
    input  logic          dropout_i,
    input  logic          plimit_i,
    input  logic          lowv_i,
    input  logic [DW-1:0] trip_cond_i,
    input  logic          opc_i,
    input  logic          qry_err_i,
    input  logic          exe_err_i,
    input  logic          cmd_err_i,
    input  logic [AW-1:0] bus_addr_i,
    input  logic          bus_wr_i,
    input  logic [DW-1:0] bus_wdata_i,
    input  logic          bus_rd_i,
    output logic [DW-1:0] bus_rdata_o,
    output logic [DW-1:0] stb_sum_o
);
    typedef struct packed {
        logic dis;
    } ctrl_s;

    ctrl_s ctl_d, ctl_q;

    reg_addr_e              addr;
    logic [DW-1:0]          istate;
    logic [DW-1:0]          trip_val;
    logic [DW-1:0]          event_val;
    logic [DW-1:0]          ev_set;
    logic                   trip_clr, ev_clr;
    logic [NMASK-1:0]       mask_wr;
    logic [NMASK-1:0][DW-1:0] mask_flags;
    logic [NMASK-1:0][DW-1:0] mask_val;
    logic [NMASK-1:0]       mask_hit;
    logic [DW-1:0]          ise_mask;

    assign addr = reg_addr_e'(bus_addr_i);

    // control register: input-disabled setting
    always_comb begin
        ctl_d = ctl_q;
        if (bus_wr_i && addr == A_CTRL) ctl_d.dis = bus_wdata_i[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q.dis <= retain_i ? saved_dis_i : 1'b1;
        else        ctl_q     <= ctl_d;
    end

    // live input state
    always_comb begin
        istate           = '0;
        istate[IS_DIS]   = ctl_q.dis;
        istate[IS_LOWV]  = lowv_i;
        istate[IS_PLIM]  = plimit_i;
        istate[IS_DROP]  = dropout_i;
        istate[IS_DUTY]  = duty_i;
        istate[IS_FAULT] = fault_i;
    end

    // event set pulses
    always_comb begin
        ev_set         = '0;
        ev_set[EV_OPC] = opc_i;
        ev_set[EV_QRY] = qry_err_i;
        ev_set[EV_EXE] = exe_err_i;
        ev_set[EV_CMD] = cmd_err_i;
    end

    assign trip_clr = bus_rd_i && addr == A_TRIP;
    assign ev_clr   = bus_rd_i && addr == A_EVENT;

    isr_trip_latch #(.DW(DW)) u_trip (
        .clk    (clk),
        .rst_n  (rst_n),
        .cond_i (trip_cond_i),
        .clr_i  (trip_clr),
        .val_o  (trip_val)
    );

    isr_event_latch #(.DW(DW), .LIVE_MASK(EV_LIVE), .RST_VAL(EV_RESET)) u_event (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (ev_set),
        .clr_i  (ev_clr),
        .val_o  (event_val)
    );

    assign mask_flags[0] = istate;
    assign mask_flags[1] = trip_val;
    assign mask_flags[2] = event_val;
    assign mask_wr[0]    = bus_wr_i && addr == A_ISTATE_EN;
    assign mask_wr[1]    = bus_wr_i && addr == A_TRIP_EN;
    assign mask_wr[2]    = bus_wr_i && addr == A_EVENT_EN;

    for (genvar g = 0; g < NMASK; g++) begin : g_mask
        isr_enable_mask #(.DW(DW)) u_mask (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_i    (mask_wr[g]),
            .wdata_i (bus_wdata_i),
            .flags_i (mask_flags[g]),
            .mask_o  (mask_val[g]),
            .hit_o   (mask_hit[g])
        );
    end

    assign ise_mask = mask_val[0];

    always_comb begin
        stb_sum_o = '0;
        for (int i = 0; i < NMASK; i++) stb_sum_o[SB_POS[i]] = mask_hit[i];
    end

    always_comb begin
        unique case (addr)
            A_ISTATE:    bus_rdata_o = istate;
            A_ISTATE_EN: bus_rdata_o = mask_val[0];
            A_TRIP:      bus_rdata_o = trip_val;
            A_TRIP_EN:   bus_rdata_o = mask_val[1];
            A_EVENT:     bus_rdata_o = event_val;
            A_EVENT_EN:  bus_rdata_o = mask_val[2];
            A_CTRL:      bus_rdata_o = {{(DW-1){1'b0}}, ctl_q.dis};
            default:     bus_rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/isr_chk.sv
module isr_chk
    import isr_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] bus_addr_i,
    input logic          bus_wr_i,
    input logic [DW-1:0] bus_wdata_i,
    input logic          bus_rd_i,
    input logic [DW-1:0] bus_rdata_o,
    input logic [DW-1:0] trip_cond_i,
    input logic [DW-1:0] ev_set,
    input logic [DW-1:0] trip_val,
    input logic [DW-1:0] event_val,
    input logic [DW-1:0] ise_mask
);
    // R1
    istate_rsv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr_i == A_ISTATE) |-> (bus_rdata_o[6:5] == 2'b00));

    // R3
    mask_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && bus_addr_i == A_ISTATE_EN) |=> (ise_mask == $past(bus_wdata_i)));

    // R5
    trip_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trip_cond_i != '0) |=> ((trip_val & $past(trip_cond_i)) == $past(trip_cond_i)));

    // R6
    trip_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_i && bus_addr_i == A_TRIP) |=> (trip_val == $past(trip_cond_i)));

    // R9
    event_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_i && bus_addr_i == A_EVENT && ev_set == '0) |=> (event_val == '0));

    // R9
    event_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_set[EV_OPC] |=> event_val[EV_OPC]);
endmodule

bind instr_status_regs isr_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr_i  (bus_addr_i),
    .bus_wr_i    (bus_wr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rd_i    (bus_rd_i),
    .bus_rdata_o (bus_rdata_o),
    .trip_cond_i (trip_cond_i),
    .ev_set      (ev_set),
    .trip_val    (trip_val),
    .event_val   (event_val),
    .ise_mask    (ise_mask)
);

// File: tb/instr_status_regs_tb.sv
module instr_status_regs_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       retain_i = 1'b0, saved_dis_i = 1'b0;
    logic       fault_i = 0, duty_i = 0, dropout_i = 0, plimit_i = 0, lowv_i = 0;
    logic [7:0] trip_cond_i = '0;
    logic       opc_i = 0, qry_err_i = 0, exe_err_i = 0, cmd_err_i = 0;
    logic [2:0] bus_addr_i = '0;
    logic       bus_wr_i = 0, bus_rd_i = 0;
    logic [7:0] bus_wdata_i = '0;
    logic [7:0] bus_rdata_o, stb_sum_o;

    int checks = 0, fails = 0, cyc = 0;
    bit done = 0;

    always #2 clk = ~clk;

    instr_status_regs u_dut (.*);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000 && !done) begin
            fails = fails + 1;
            $display("FAIL watchdog: run did not finish (act=hung exp=done)");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: act=%02h exp=%02h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic ret, input logic sv);
        @(negedge clk);
        retain_i = ret; saved_dis_i = sv; rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr_i = a; bus_wdata_i = d; bus_wr_i = 1;
        @(negedge clk);
        bus_wr_i = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr_i = a; bus_rd_i = 1;
        #1 v = bus_rdata_o;
        @(negedge clk);
        bus_rd_i = 0;
    endtask

    logic [7:0] v, exp_s;

    initial begin
        do_reset(1'b0, 1'b0);
        // reset state
        rd(3'd0, v); chk("R2 reset dis=1", v, 8'h01);
        chk("R10 reset stb", stb_sum_o, 8'h00);
        rd(3'd2, v); chk("R5 trip reset", v, 8'h00);
        rd(3'd1, v); chk("R3 state mask reset", v, 8'h00);
        rd(3'd3, v); chk("R3 trip mask reset", v, 8'h00);
        rd(3'd5, v); chk("R3 event mask reset", v, 8'h00);
        rd(3'd4, v); chk("R8 event reset 80", v, 8'h80);
        rd(3'd4, v); chk("R9 event cleared", v, 8'h00);

        // R3 mask readback sweep
        for (int a = 1; a <= 5; a += 2) begin
            for (int d = 0; d < 256; d++) begin
                wr(3'(a), 8'(d));
                rd(3'(a), v);
                chk("R3 mask readback", v, 8'(d));
            end
            wr(3'(a), 8'h00);
        end

        // R1 / R4 sweep of conditions against masks
        for (int m = 0; m < 9; m++) begin
            logic [7:0] mk;
            mk = (m == 8) ? 8'hFF : 8'(1 << m);
            wr(3'd1, mk);
            for (int s = 0; s < 64; s++) begin
                @(negedge clk);
                fault_i = s[0]; duty_i = s[1]; dropout_i = s[2];
                plimit_i = s[3]; lowv_i = s[4];
                if (s[5] != v[0]) wr(3'd6, {7'd0, s[5]});
                exp_s = {fault_i, 2'b00, duty_i, dropout_i, plimit_i, lowv_i, s[5]};
                rd(3'd0, v);
                chk("R1 live state", v, exp_s);
                chk("R4 state summary", stb_sum_o, ((exp_s & mk) != 0) ? 8'h01 : 8'h00);
                rd(3'd0, v);
                chk("R1 read no side effect", v, exp_s);
            end
        end
        @(negedge clk);
        fault_i = 0; duty_i = 0; dropout_i = 0; plimit_i = 0; lowv_i = 0;
        wr(3'd1, 8'h00);
        wr(3'd6, 8'h01);

        // R5/R6/R7 trip behaviour for every bit
        wr(3'd3, 8'hFF);
        for (int b = 0; b < 8; b++) begin
            @(negedge clk); trip_cond_i = 8'(1 << b);
            @(negedge clk); trip_cond_i = '0;
            #1 chk("R7 trip summary", stb_sum_o, 8'h02);
            rd(3'd2, v); chk("R5 trip latched", v, 8'(1 << b));
            rd(3'd2, v); chk("R6 trip cleared", v, 8'h00);
            chk("R7 trip summary low", stb_sum_o, 8'h00);
        end
        // held condition survives read, pulsed one does not
        @(negedge clk); trip_cond_i = 8'h24;
        @(negedge clk); trip_cond_i = 8'h04;
        rd(3'd2, v); chk("R6 pre-clear value", v, 8'h24);
        rd(3'd2, v); chk("R6 held bit stays", v, 8'h04);
        @(negedge clk); trip_cond_i = 8'h00;
        rd(3'd2, v); chk("R6 latched after drop", v, 8'h04);
        rd(3'd2, v); chk("R6 cleared after drop", v, 8'h00);
        wr(3'd3, 8'h20);
        @(negedge clk); trip_cond_i = 8'h04;
        @(negedge clk); trip_cond_i = 8'h00;
        #1 chk("R7 masked trip no summary", stb_sum_o, 8'h00);
        rd(3'd2, v);
        wr(3'd3, 8'h00);

        // R8/R9/R10 events
        wr(3'd5, 8'hFF);
        for (int e = 0; e < 4; e++) begin
            logic [7:0] eb;
            eb = (e == 0) ? 8'h01 : (e == 1) ? 8'h04 : (e == 2) ? 8'h10 : 8'h20;
            @(negedge clk);
            opc_i = (e == 0); qry_err_i = (e == 1); exe_err_i = (e == 2); cmd_err_i = (e == 3);
            @(negedge clk);
            opc_i = 0; qry_err_i = 0; exe_err_i = 0; cmd_err_i = 0;
            #1 chk("R10 event summary", stb_sum_o, 8'h20);
            rd(3'd4, v); chk("R8 event bit", v, eb);
            rd(3'd4, v); chk("R9 event cleared", v, 8'h00);
            chk("R10 event summary low", stb_sum_o, 8'h00);
        end
        // set and clear in one cycle: set wins
        @(negedge clk); exe_err_i = 1;
        @(negedge clk); exe_err_i = 0;
        @(negedge clk);
        bus_addr_i = 3'd4; bus_rd_i = 1; opc_i = 1;
        #1 v = bus_rdata_o;
        chk("R9 read value before set", v, 8'h10);
        @(negedge clk); bus_rd_i = 0; opc_i = 0;
        rd(3'd4, v); chk("R9 set wins over clear", v, 8'h01);
        wr(3'd5, 8'h01);
        @(negedge clk); cmd_err_i = 1;
        @(negedge clk); cmd_err_i = 0;
        #1 chk("R10 masked event no summary", stb_sum_o, 8'h00);
        rd(3'd4, v);

        // R2 retain option
        do_reset(1'b1, 1'b0);
        rd(3'd0, v); chk("R2 retain saved 0", v, 8'h00);
        rd(3'd4, v); chk("R8 event reset again", v, 8'h80);
        rd(3'd5, v); chk("R3 mask reset again", v, 8'h00);
        do_reset(1'b1, 1'b1);
        rd(3'd0, v); chk("R2 retain saved 1", v, 8'h01);
        wr(3'd6, 8'hFE);
        rd(3'd0, v); chk("R2 ctrl write", v, 8'h00);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule